// File: doc/BRIEF.md
# Software Interrupt Request Register

A single 16-bit register through which software raises interrupts against itself on any of seven priority levels. Writing the upper byte sets or clears one request bit per level. The lower byte is read-only. It always reflects the highest pending level, and the level number appears in two places within that byte. A small arbiter compares that level with the processor priority on every cycle. It raises an interrupt request, with a fixed vector, whenever the pending level is strictly above the priority.

The request output follows a valid/ready pattern. `irq_valid` carries `irq_level` and `irq_vector`, and `irq_ack` is the ready side. The block applies no back-pressure, and the handshake does not consume anything. An acknowledge leaves every request bit as it was. `irq_valid` stays high for as long as the comparison holds. It drops without any acknowledge as soon as software raises `cpu_pri` to the pending level or clears the bit. Only software removes a request, by writing its bit to zero. A higher level that is set during a lower-level service raises `irq_valid` in the cycle after the write. This gives nested servicing, highest level first.

Top module: `swirq_reg`

## Requirements
- R1: A write with `bus_be[1]` high loads `bus_wdata[15:9]` into the request bits. Level n (1..7) occupies register bit 8+n, and the new value is visible on `bus_rdata` one cycle after the write.
- R2: `bus_rdata[7:0]` equals the highest pending level times octal 042. The level therefore reads in bits 7:5 and again in bits 3:1, and bits 4 and 0 read zero.
- R3: With no request bit set, `bus_rdata` reads 0x0000.
- R4: Register bits 8 and 0 always read 0, and writing ones to them changes nothing.
- R5: A write with `bus_be[1]` low, whether it is a low-byte-only write or carries no enables, leaves `bus_rdata` unchanged.
- R6: `irq_valid` is high exactly when the highest pending level is strictly greater than `cpu_pri`. At priority 7 it is never high.
- R7: `irq_level` always equals the highest pending level (0 when none is pending), and `irq_vector` is octal 240.
- R8: `irq_ack` does not clear or change any request bit.
- R9: A synchronous `rst` clears all request bits and deasserts `irq_valid`.
- R10: Lowering the priority step by step services pending levels highest first. Example: with levels 1 and 3 pending, and each handler clearing its own bit and setting new ones (7 while in 3, then 6 and 4 while in 7, then 5 and 2 while in 4), the service order is 3, 7, 6, 4, 5, 2, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_be | input | 2 | Byte enables: bit 1 selects the upper byte, bit 0 the lower byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register value |
| cpu_pri | input | 3 | Current processor priority |
| irq_valid | output | 1 | Interrupt request |
| irq_level | output | 3 | Highest pending level |
| irq_vector | output | 9 | Interrupt vector, octal 240 |
| irq_ack | input | 1 | Acknowledge (ready side of the request) |

## Verification
The bench builds the block with its default parameters: a 3-bit level field, seven request levels and vector octal 240. This brings every level and the priority-7 lockout within reach, along with the equal-priority boundary where no request may be raised. A software-style service loop drives the full nesting chain. It checks that newly set higher levels preempt at once and that lower ones wait until priorities are restored.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int LVL_W_DEF = 3;
  localparam int DATA_W_DEF = 16;
  localparam int VEC_W_DEF = 9;
  localparam logic [VEC_W_DEF-1:0] VECTOR_DEF = 9'o240;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/swirq_req_bank.sv
module swirq_req_bank #(
  parameter int NUM_LVL = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NUM_LVL-1:0] wr_bits,
  output logic [NUM_LVL-1:0] req_q
);
  // one flop per level; level n is index n-1
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst)        req_q[g] <= 1'b0;
      else if (wr_en) req_q[g] <= wr_bits[g];
    end
  end
endmodule

// File: rtl/swirq_prio_enc.sv
module swirq_prio_enc #(
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] req,
  output logic [LVL_W-1:0]   top_lvl
);
  // scan upward so the highest set level wins
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (req[i]) top_lvl = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/swirq_gate.sv
module swirq_gate #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] top_lvl,
  input  logic [LVL_W-1:0] pri,
  output logic             take
);
  // strict comparison: equal priority masks the request
  assign take = (top_lvl > pri);
endmodule

// File: rtl/swirq_reg.sv
module swirq_reg #(
  parameter int LVL_W  = swirq_pkg::LVL_W_DEF,
  parameter int DATA_W = swirq_pkg::DATA_W_DEF,
  parameter int VEC_W  = swirq_pkg::VEC_W_DEF,
  parameter logic [VEC_W-1:0] IRQ_VECTOR = swirq_pkg::VECTOR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LVL_W-1:0]  cpu_pri,
  output logic              irq_valid,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack
);
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int REQ_LSB = DATA_W - NUM_LVL;
  localparam int LOW_W   = swirq_pkg::BYTE_W;

  logic [NUM_LVL-1:0] req_q;
  logic [LVL_W-1:0]   top_lvl;
  logic               wr_hi;
  logic [LOW_W-1:0]   low_fields;

  // only the upper-byte lane reaches storage; the lower byte is derived
  assign wr_hi = bus_wr & bus_be[1];

  swirq_req_bank #(.NUM_LVL(NUM_LVL)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_hi),
    .wr_bits(bus_wdata[DATA_W-1:REQ_LSB]),
    .req_q  (req_q)
  );

  swirq_prio_enc #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_enc (
    .req    (req_q),
    .top_lvl(top_lvl)
  );

  swirq_gate #(.LVL_W(LVL_W)) u_gate (
    .top_lvl(top_lvl),
    .pri    (cpu_pri),
    .take   (irq_valid)
  );

  // level mirrored into two fields of the lower byte (level * octal 042)
  always_comb begin
    low_fields = '0;
    low_fields[LOW_W-1 -: LVL_W] = top_lvl;
    low_fields[LVL_W:1]          = top_lvl;
  end

  always_comb begin
    bus_rdata = '0;
    bus_rdata[DATA_W-1:REQ_LSB] = req_q;
    bus_rdata[LOW_W-1:0]        = low_fields;
  end

  assign irq_level  = top_lvl;
  assign irq_vector = IRQ_VECTOR;
endmodule

// File: rtl/swirq_reg_chk.sv
module swirq_reg_chk #(
  parameter int LVL_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [1:0]        bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LVL_W-1:0]  cpu_pri,
  input logic              irq_valid,
  input logic [LVL_W-1:0]  irq_level,
  input logic              irq_ack
);
  localparam logic [LVL_W-1:0] PRI_MAX = '1;

  assert_upper_write_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_be[1]) |=> (bus_rdata[DATA_W-1:9] == $past(bus_wdata[DATA_W-1:9])));

  assert_fields_agree_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[7:5] == irq_level) && (bus_rdata[3:1] == irq_level));

  assert_empty_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[DATA_W-1:9] == '0) |-> (bus_rdata == '0));

  assert_unimpl_bits_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata[8] && !bus_rdata[0]);

  assert_low_only_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_be[1]) |=> $stable(bus_rdata));

  assert_strictly_above_R6: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_level > cpu_pri));

  assert_pri_max_masks_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_pri == PRI_MAX) |-> !irq_valid);

  assert_ack_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind swirq_reg swirq_reg_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_be   (bus_be),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cpu_pri  (cpu_pri),
  .irq_valid(irq_valid),
  .irq_level(irq_level),
  .irq_ack  (irq_ack)
);

// File: tb/swirq_reg_tb.sv
module swirq_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  cpu_pri = 3'd0;
  logic        irq_valid;
  logic [2:0]  irq_level;
  logic [8:0]  irq_vector;
  logic        irq_ack = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swirq_reg u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_pri(cpu_pri),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector),
    .irq_ack(irq_ack)
  );

  // be, wdata, pri | expected rdata, valid, level
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {2'b11, 16'h0A00, 3'd7, 16'h0A66, 1'b0, 3'd3},
    {2'b11, 16'h0A00, 3'd2, 16'h0A66, 1'b1, 3'd3},
    {2'b11, 16'h0A00, 3'd3, 16'h0A66, 1'b0, 3'd3},
    {2'b10, 16'h81FF, 3'd6, 16'h80EE, 1'b1, 3'd7},
    {2'b01, 16'h7F00, 3'd0, 16'h80EE, 1'b1, 3'd7},
    {2'b11, 16'h0000, 3'd0, 16'h0000, 1'b0, 3'd0},
    {2'b11, 16'h5400, 3'd5, 16'h54CC, 1'b1, 3'd6},
    {2'b11, 16'h0201, 3'd0, 16'h0222, 1'b1, 3'd1},
    {2'b00, 16'hFFFF, 3'd1, 16'h0222, 1'b0, 3'd1},
    {2'b11, 16'h2000, 3'd4, 16'h20AA, 1'b1, 3'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    bus_wr = 1'b1; bus_be = be; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_order [7] = '{3, 7, 6, 4, 5, 2, 1};
    int stk [8];
    int sp;
    int idx;
    logic [7:0] up;
    logic [7:0] newb;
    int lvl;

    @(negedge clk);
    step();
    rst = 1'b0;
    // R9: reset state
    check("R9 reset rdata", int'(bus_rdata), 0);
    check("R9 reset valid", int'(irq_valid), 0);
    check("R7 vector", int'(irq_vector), 'o240);

    // table walk: R1..R7
    for (int i = 0; i < NV; i++) begin
      cpu_pri = VEC[i][22:20];
      wr(VEC[i][40:39], VEC[i][38:23]);
      check("R1/R2/R3/R4/R5 rdata", int'(bus_rdata), int'(VEC[i][19:4]));
      check("R6 valid", int'(irq_valid), int'(VEC[i][3]));
      check("R7 level", int'(irq_level), int'(VEC[i][2:0]));
    end

    // R6: priority 7 masks even level 7
    wr(2'b11, 16'hFE00);
    cpu_pri = 3'd7;
    #1;
    check("R6 pri7 masked", int'(irq_valid), 0);
    cpu_pri = 3'd6;
    #1;
    check("R6 pri6 level7", int'(irq_valid), 1);

    // R8: acknowledge leaves bits alone
    wr(2'b11, 16'h1000);
    cpu_pri = 3'd0;
    irq_ack = 1'b1;
    step();
    step();
    irq_ack = 1'b0;
    check("R8 ack rdata", int'(bus_rdata), 'h1088);
    check("R8 ack valid", int'(irq_valid), 1);

    // R9: reset with bits pending
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R9 mid reset rdata", int'(bus_rdata), 0);
    check("R9 mid reset valid", int'(irq_valid), 0);

    // R10: nested service sequence
    cpu_pri = 3'd7;
    wr(2'b11, 16'h0A00);
    cpu_pri = 3'd0;
    #1;
    sp = 0;
    idx = 0;
    for (int it = 0; it < 40; it++) begin
      if (irq_valid) begin
        lvl = int'(irq_level);
        if (idx < 7) check("R10 service order", lvl, exp_order[idx]);
        idx++;
        stk[sp] = int'(cpu_pri);
        sp++;
        cpu_pri = 3'(lvl);
        up = bus_rdata[15:8] & ~(8'h01 << lvl);
        case (lvl)
          3: newb = 8'h80;
          7: newb = 8'h50;
          4: newb = 8'h24;
          default: newb = 8'h00;
        endcase
        wr(2'b11, {up | newb, 8'h00});
      end else if (sp > 0) begin
        sp--;
        cpu_pri = 3'(stk[sp]);
        #1;
      end else begin
        break;
      end
    end
    check("R10 services taken", idx, 7);
    check("R3 drained rdata", int'(bus_rdata), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule